// File: doc/BRIEF.md
# SD host interrupt status controller

This block gathers the completion, transfer and error events of an SD/SDIO host into one 32-bit status word. The word sits beside a 32-bit mask, and together they drive a single interrupt line. The command engine, the data engine and the CRC logic are not part of it. Each of them reports to this block through a one-cycle pulse input. A pulse latches its status bit, and the bit stays set until software writes a 0 to that position. Writing a 1 to a position leaves that bit alone. The same word also shows two live levels: card present, which comes from a synchronized card-detect pin, and write protect. Neither live level can raise the interrupt.

A separate 16-bit group handles the SDIO card interrupt. It has an enable register, a status register and a mask register, and it drives a second interrupt line. A soft-reset register holds all interrupt state in its reset condition while it contains 0. Software releases the block by writing 1 to it. A second read-only word passes a detailed error code through to software.

Register offsets, as byte addresses on a single-cycle write bus with a combinational read: status 0x1C, mask 0x20, error detail 0x2C, SDIO enable 0x34, SDIO status 0x36, SDIO mask 0x38, soft reset 0xE0. Any other offset reads 0.

Top module: `sdirq_ctrl`

## Requirements
- R1: After `rst`, the registers read as follows: sticky status bits 0, mask 0xFFFFFFFF, SDIO enable 0, SDIO status 0, SDIO mask 0x0000FFFF, soft reset 1. Both interrupt lines are low.
- R2: Each event pulse sets its status bit at the next clock edge, and the bit stays set after the pulse ends. The bits are: command response end bit 0, data end bit 2, receive ready bit 24, transmit request bit 25, command ready bit 29, command busy bit 30. For `err_pulse[i]`, i = 0..6 sets bit 16+i, and `err_pulse[7]` sets bit 31.
- R3: A write to status clears every sticky bit written as 0 and leaves every bit written as 1 unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when some sticky status bit is set and its mask bit is 0. A mask bit of 1 suppresses that source. `irq` follows the status register with no added delay.
- R6: Status bit 5 shows the synchronized card-detect level and bit 7 shows `write_prot`. Neither bit drives `irq`, and writes to status do not change them.
- R7: `card_detect_raw` passes through two synchronizing flops. A rising level sets status bit 4 (inserted) and a falling level sets bit 3 (removed). The sticky bit is readable three clock edges after the input changes. Bit 5 updates one edge earlier.
- R8: An `sdio_card_pulse` sets SDIO status bit 0. Writing 0 to that bit clears it. `sdio_irq` = enable bit 0 AND status bit 0 AND NOT SDIO mask bit 0.
- R9: While the soft-reset register holds 0, the block behaves as follows: all sticky status is 0, the masks read all ones, events are ignored, and writes to the other registers have no effect. Writing 1 releases the block.
- R10: Offset 0x2C reads `err_detail`. Unmapped offsets read 0.
- R11: The mask register stores and reads back all 32 bits. Status positions that are neither sticky nor live read 0 and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (9) | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_cmd_resp | input | 1 | Command response end pulse |
| evt_data_end | input | 1 | Data end pulse |
| evt_rx_ready | input | 1 | Receive ready pulse |
| evt_tx_req | input | 1 | Transmit request pulse |
| evt_cmd_ready | input | 1 | Command ready pulse |
| evt_cmd_busy | input | 1 | Command busy pulse |
| err_pulse | input | 8 | Error pulses |
| card_detect_raw | input | 1 | Asynchronous card-detect level |
| write_prot | input | 1 | Write-protect level |
| sdio_card_pulse | input | 1 | SDIO card interrupt pulse |
| err_detail | input | 32 | Detailed error code, read at 0x2C |
| irq | output | 1 | Main interrupt |
| sdio_irq | output | 1 | SDIO card interrupt |

## Verification
Every internal flop in this block becomes visible at the ports within one or two cycles. A bit that latches wrongly or clears wrongly shows up in the next status read. It also shows up on `irq` in the cycle after the edge, once its mask bit is opened. A card-detect synchronizer with the wrong depth moves the inserted and removed bits by one edge, and the bench reads those bits at a fixed three-edge distance, so the shift is caught. A soft-reset domain that leaks shows up as an event bit or a mask write that survives while the hold is active.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

    localparam int STAT_W = 32;
    localparam int SDIO_W = 16;
    localparam int ERR_N  = 8;

    // Register byte offsets
    localparam int OFS_STAT      = 'h01C;
    localparam int OFS_MASK      = 'h020;
    localparam int OFS_ERRD      = 'h02C;
    localparam int OFS_SDIO_EN   = 'h034;
    localparam int OFS_SDIO_STAT = 'h036;
    localparam int OFS_SDIO_MASK = 'h038;
    localparam int OFS_SRST      = 'h0E0;

    // Status bit positions
    localparam int B_CMD_RESP  = 0;
    localparam int B_DATA_END  = 2;
    localparam int B_CARD_REM  = 3;
    localparam int B_CARD_INS  = 4;
    localparam int B_CARD_LVL  = 5;
    localparam int B_WPROT     = 7;
    localparam int B_ERR_LO    = 16;
    localparam int B_RX_READY  = 24;
    localparam int B_TX_REQ    = 25;
    localparam int B_CMD_READY = 29;
    localparam int B_CMD_BUSY  = 30;
    localparam int B_ERR_HI    = 31;

    localparam logic [STAT_W-1:0] STICKY_BITS = 32'hE37F_001D;
    localparam logic [SDIO_W-1:0] SDIO_STICKY = 16'h0001;

    typedef struct packed {
        logic             cmd_resp;
        logic             data_end;
        logic             rx_ready;
        logic             tx_req;
        logic             cmd_ready;
        logic             cmd_busy;
        logic [ERR_N-1:0] err;
        logic             card_ins;
        logic             card_rem;
    } evt_t;

    function automatic logic [STAT_W-1:0] evt_to_status(evt_t e);
        logic [STAT_W-1:0] s;
        s = '0;
        s[B_CMD_RESP]  = e.cmd_resp;
        s[B_DATA_END]  = e.data_end;
        s[B_CARD_REM]  = e.card_rem;
        s[B_CARD_INS]  = e.card_ins;
        s[B_RX_READY]  = e.rx_ready;
        s[B_TX_REQ]    = e.tx_req;
        s[B_CMD_READY] = e.cmd_ready;
        s[B_CMD_BUSY]  = e.cmd_busy;
        for (int i = 0; i < ERR_N - 1; i++) s[B_ERR_LO + i] = e.err[i];
        s[B_ERR_HI]    = e.err[ERR_N-1];
        return s;
    endfunction

endpackage

// File: rtl/sdirq_sticky.sv
module sdirq_sticky #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_we,
    input  logic [W-1:0] clr_n,
    output logic [W-1:0] q
);

    logic [W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (clr_we) nxt = nxt & clr_n;
        nxt = (nxt | set) & KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R4: a pulse always lands, even against a clearing write
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        ((set & KEEP) != '0) |=> ((q & $past(set) & KEEP) == ($past(set) & KEEP)));

    // R3: clearing write with no events keeps only the bits written as 1
    a_r3_zero_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_we && set == '0) |=> (q == ($past(q) & $past(clr_n))));

    // R2: without a write or an event the bits do not move
    a_r2_no_spontaneous: assert property (@(posedge clk) disable iff (rst)
        (!clr_we && set == '0) |=> $stable(q));

endmodule

// File: rtl/sdirq_cd_edge.sv
module sdirq_cd_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cd_raw,
    output logic level,
    output logic ins,
    output logic rem
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cd_raw};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level = sync_q[SYNC_STAGES-1];
    assign ins   = level & ~last_q;
    assign rem   = ~level & last_q;

    // R7: insert and remove never fire together
    a_r7_edge_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ins, rem}));

    // R7: an insert pulse lasts one cycle
    a_r7_ins_single: assert property (@(posedge clk) disable iff (rst)
        ins |=> !ins);

endmodule

// File: rtl/sdirq_ctrl.sv
module sdirq_ctrl
    import sdirq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              evt_cmd_resp,
    input  logic              evt_data_end,
    input  logic              evt_rx_ready,
    input  logic              evt_tx_req,
    input  logic              evt_cmd_ready,
    input  logic              evt_cmd_busy,
    input  logic [7:0]        err_pulse,
    input  logic              card_detect_raw,
    input  logic              write_prot,
    input  logic              sdio_card_pulse,
    input  logic [31:0]       err_detail,
    output logic              irq,
    output logic              sdio_irq
);

    logic              run_q;
    logic              core_rst;
    logic              cd_level, cd_ins, cd_rem;
    evt_t              evt;
    logic [STAT_W-1:0] stat_set, stat_q, mask_q, live_bits;
    logic [SDIO_W-1:0] sdio_set, sdio_stat_q, sdio_mask_q;
    logic              sdio_en_q;
    logic              hit_stat, hit_mask, hit_sdio_en, hit_sdio_stat, hit_sdio_mask, hit_srst;

    assign core_rst = rst | ~run_q;

    always_comb begin
        hit_stat      = bus_we && run_q && bus_addr == ADDR_W'(OFS_STAT);
        hit_mask      = bus_we && run_q && bus_addr == ADDR_W'(OFS_MASK);
        hit_sdio_en   = bus_we && run_q && bus_addr == ADDR_W'(OFS_SDIO_EN);
        hit_sdio_stat = bus_we && run_q && bus_addr == ADDR_W'(OFS_SDIO_STAT);
        hit_sdio_mask = bus_we && run_q && bus_addr == ADDR_W'(OFS_SDIO_MASK);
        hit_srst      = bus_we && bus_addr == ADDR_W'(OFS_SRST);
    end

    // Soft reset register: only the hard reset touches it
    always_ff @(posedge clk) begin
        if (rst)           run_q <= 1'b1;
        else if (hit_srst) run_q <= bus_wdata[0];
    end

    sdirq_cd_edge #(.SYNC_STAGES(2)) u_cd (
        .clk    (clk),
        .rst    (rst),
        .cd_raw (card_detect_raw),
        .level  (cd_level),
        .ins    (cd_ins),
        .rem    (cd_rem)
    );

    always_comb begin
        evt.cmd_resp  = evt_cmd_resp;
        evt.data_end  = evt_data_end;
        evt.rx_ready  = evt_rx_ready;
        evt.tx_req    = evt_tx_req;
        evt.cmd_ready = evt_cmd_ready;
        evt.cmd_busy  = evt_cmd_busy;
        evt.err       = err_pulse;
        evt.card_ins  = cd_ins;
        evt.card_rem  = cd_rem;
        stat_set      = evt_to_status(evt);
        sdio_set      = {{(SDIO_W-1){1'b0}}, sdio_card_pulse};
    end

    sdirq_sticky #(.W(STAT_W), .KEEP(STICKY_BITS)) u_stat (
        .clk    (clk),
        .rst    (core_rst),
        .set    (stat_set),
        .clr_we (hit_stat),
        .clr_n  (bus_wdata),
        .q      (stat_q)
    );

    sdirq_sticky #(.W(SDIO_W), .KEEP(SDIO_STICKY)) u_sdio (
        .clk    (clk),
        .rst    (core_rst),
        .set    (sdio_set),
        .clr_we (hit_sdio_stat),
        .clr_n  (bus_wdata[SDIO_W-1:0]),
        .q      (sdio_stat_q)
    );

    always_ff @(posedge clk) begin
        if (core_rst) begin
            mask_q      <= '1;
            sdio_mask_q <= '1;
            sdio_en_q   <= 1'b0;
        end else begin
            if (hit_mask)      mask_q      <= bus_wdata;
            if (hit_sdio_mask) sdio_mask_q <= bus_wdata[SDIO_W-1:0];
            if (hit_sdio_en)   sdio_en_q   <= bus_wdata[0];
        end
    end

    always_comb begin
        live_bits             = '0;
        live_bits[B_CARD_LVL] = cd_level;
        live_bits[B_WPROT]    = write_prot;
    end

    assign irq      = |(stat_q & ~mask_q);
    assign sdio_irq = sdio_en_q & sdio_stat_q[0] & ~sdio_mask_q[0];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_STAT):      bus_rdata = stat_q | live_bits;
            ADDR_W'(OFS_MASK):      bus_rdata = mask_q;
            ADDR_W'(OFS_ERRD):      bus_rdata = err_detail;
            ADDR_W'(OFS_SDIO_EN):   bus_rdata = {31'b0, sdio_en_q};
            ADDR_W'(OFS_SDIO_STAT): bus_rdata = {{(32-SDIO_W){1'b0}}, sdio_stat_q};
            ADDR_W'(OFS_SDIO_MASK): bus_rdata = {{(32-SDIO_W){1'b0}}, sdio_mask_q};
            ADDR_W'(OFS_SRST):      bus_rdata = {31'b0, run_q};
            default:                bus_rdata = '0;
        endcase
    end

    // R8: a disabled SDIO group stays silent
    a_r8_sdio_gated: assert property (@(posedge clk) disable iff (rst)
        !sdio_en_q |-> !sdio_irq);

    // R9: holding soft reset empties the status word by the next edge
    a_r9_hold_clears: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> (stat_q == '0 && sdio_stat_q == '0));

    // R5: a fully masked word never interrupts
    a_r5_all_masked: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq);

    // R6: live levels alone never interrupt
    a_r6_live_silent: assert property (@(posedge clk) disable iff (rst)
        (stat_q == '0) |-> !irq);

endmodule

// File: tb/sdirq_ctrl_test.sv
module sdirq_ctrl_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_cmd_resp = 0, evt_data_end = 0, evt_rx_ready = 0, evt_tx_req = 0;
    logic        evt_cmd_ready = 0, evt_cmd_busy = 0;
    logic [7:0]  err_pulse = '0;
    logic        card_detect_raw = 0, write_prot = 0, sdio_card_pulse = 0;
    logic [31:0] err_detail = '0;
    logic        irq, sdio_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    sdirq_ctrl uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_cmd_resp(evt_cmd_resp), .evt_data_end(evt_data_end),
        .evt_rx_ready(evt_rx_ready), .evt_tx_req(evt_tx_req),
        .evt_cmd_ready(evt_cmd_ready), .evt_cmd_busy(evt_cmd_busy),
        .err_pulse(err_pulse), .card_detect_raw(card_detect_raw),
        .write_prot(write_prot), .sdio_card_pulse(sdio_card_pulse),
        .err_detail(err_detail), .irq(irq), .sdio_irq(sdio_irq)
    );

    localparam logic [8:0] A_STAT = 9'h01C, A_MASK = 9'h020, A_ERRD = 9'h02C;
    localparam logic [8:0] A_SEN = 9'h034, A_SSTAT = 9'h036, A_SMASK = 9'h038, A_SRST = 9'h0E0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STAT, v);  chk("R1 status", v, 32'h0);
        rd(A_MASK, v);  chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(A_SEN, v);   chk("R1 sdio en", v, 32'h0);
        rd(A_SSTAT, v); chk("R1 sdio stat", v, 32'h0);
        rd(A_SMASK, v); chk("R1 sdio mask", v, 32'h0000_FFFF);
        rd(A_SRST, v);  chk("R1 srst", v, 32'h1);
        chk("R1 irq lines", {30'b0, irq, sdio_irq}, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        @(negedge clk);
        evt_cmd_resp = 1; evt_data_end = 1; evt_rx_ready = 1;
        evt_tx_req = 1; evt_cmd_ready = 1; evt_cmd_busy = 1; err_pulse = 8'hFF;
        @(negedge clk);
        evt_cmd_resp = 0; evt_data_end = 0; evt_rx_ready = 0;
        evt_tx_req = 0; evt_cmd_ready = 0; evt_cmd_busy = 0; err_pulse = 8'h00;
        @(negedge clk);
        rd(A_STAT, v); chk("R2 all events sticky", v, 32'hE37F_0005);
        chk("R5 masked events no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); chk("R3 clear bit0 only", v, 32'hE37F_0004);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R3 clear all", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 32'h0; bus_we = 1'b1; evt_data_end = 1;
        @(negedge clk);
        bus_we = 1'b0; evt_data_end = 0;
        rd(A_STAT, v); chk("R4 set beats clear", v, 32'h0000_0004);
        wr(A_STAT, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_FFFE);
        rd(A_MASK, v); chk("R11 mask readback", v, 32'hFFFF_FFFE);
        @(negedge clk); evt_data_end = 1; @(negedge clk); evt_data_end = 0;
        chk("R5 masked bit2 silent", {31'b0, irq}, 32'h0);
        @(negedge clk); evt_cmd_resp = 1;
        @(posedge clk); #1;
        chk("R5 irq right after edge", {31'b0, irq}, 32'h1);
        @(negedge clk); evt_cmd_resp = 0;
        wr(A_STAT, 32'hFFFF_FFFE);
        chk("R5 irq drops on clear", {31'b0, irq}, 32'h0);
        wr(A_STAT, 32'h0);
        wr(A_MASK, 32'hFFFF_FFFF);
    endtask

    task automatic t_live();
        logic [31:0] v;
        @(negedge clk); write_prot = 1;
        wr(A_MASK, 32'h0);
        rd(A_STAT, v); chk("R6 wp level", v, 32'h0000_0080);
        chk("R6 live bit no irq", {31'b0, irq}, 32'h0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R6 live bit not writable", v, 32'h0000_0080);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R11 reserved reads 0", v, 32'h0000_0080);
        @(negedge clk); write_prot = 0;
        wr(A_MASK, 32'hFFFF_FFFF);
    endtask

    task automatic t_card();
        logic [31:0] v;
        @(negedge clk); card_detect_raw = 1;
        @(negedge clk); @(negedge clk);
        rd(A_STAT, v); chk("R7 level after 2 edges, no event yet", v, 32'h0000_0020);
        @(negedge clk);
        rd(A_STAT, v); chk("R7 insert after 3 edges", v, 32'h0000_0030);
        wr(A_MASK, 32'hFFFF_FFEF);
        chk("R7 insert irq", {31'b0, irq}, 32'h1);
        @(negedge clk); card_detect_raw = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rd(A_STAT, v); chk("R7 remove event", v, 32'h0000_0018);
        wr(A_STAT, 32'h0);
        wr(A_MASK, 32'hFFFF_FFFF);
    endtask

    task automatic t_sdio();
        logic [31:0] v;
        @(negedge clk); sdio_card_pulse = 1; @(negedge clk); sdio_card_pulse = 0;
        rd(A_SSTAT, v); chk("R8 sdio status set", v, 32'h1);
        chk("R8 sdio disabled", {31'b0, sdio_irq}, 32'h0);
        wr(A_SEN, 32'h1);
        chk("R8 sdio still masked", {31'b0, sdio_irq}, 32'h0);
        wr(A_SMASK, 32'h0000_FFFE);
        chk("R8 sdio irq", {31'b0, sdio_irq}, 32'h1);
        wr(A_SSTAT, 32'h0);
        rd(A_SSTAT, v); chk("R8 sdio cleared", v, 32'h0);
        chk("R8 sdio irq low", {31'b0, sdio_irq}, 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        @(negedge clk); evt_cmd_resp = 1; @(negedge clk); evt_cmd_resp = 0;
        wr(A_MASK, 32'h0);
        chk("R9 irq before hold", {31'b0, irq}, 32'h1);
        wr(A_SRST, 32'h0);
        rd(A_SRST, v);  chk("R9 srst reads 0", v, 32'h0);
        @(negedge clk);
        rd(A_STAT, v);  chk("R9 status cleared", v, 32'h0);
        rd(A_MASK, v);  chk("R9 mask restored", v, 32'hFFFF_FFFF);
        rd(A_SEN, v);   chk("R9 sdio en cleared", v, 32'h0);
        chk("R9 irq low in hold", {30'b0, irq, sdio_irq}, 32'h0);
        @(negedge clk); evt_tx_req = 1; @(negedge clk); evt_tx_req = 0;
        rd(A_STAT, v);  chk("R9 event ignored", v, 32'h0);
        wr(A_MASK, 32'h0);
        rd(A_MASK, v);  chk("R9 write ignored", v, 32'hFFFF_FFFF);
        wr(A_SRST, 32'h1);
        rd(A_SRST, v);  chk("R9 released", v, 32'h1);
        wr(A_MASK, 32'h1234_5678);
        rd(A_MASK, v);  chk("R9 writes after release", v, 32'h1234_5678);
        wr(A_MASK, 32'hFFFF_FFFF);
    endtask

    task automatic t_detail();
        logic [31:0] v;
        @(negedge clk); err_detail = 32'hA5C3_1E07;
        rd(A_ERRD, v);     chk("R10 error detail", v, 32'hA5C3_1E07);
        rd(9'h040, v);     chk("R10 unmapped", v, 32'h0);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_events();
        t_clear();
        t_set_wins();
        t_irq();
        t_live();
        t_card();
        t_sdio();
        t_soft_reset();
        t_detail();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule